// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Sequencer

This block moves a small processor system between normal operation and three low-power levels, then brings it back out in a controlled way. Software asks for a level by writing a two-bit code. At the next clock edge the sequencer gates the processor clock and, depending on the level, also the peripheral clocks, the main crystal oscillator, the internal RC oscillator output and the RC oscillator supply. Entering either of the two deepest levels shuts down and disconnects the PLL and issues a one-cycle pulse that clears the processor and USB clock dividers. No other register is disturbed.

The light level wakes on any enabled interrupt. The two deep levels wake only on an interrupt that can be detected without clocks. On a wake the sequencer holds the processor clock off while the restarting source settles. The length of that hold depends on which oscillator drove the system when the level was entered: a short count for the RC oscillator, a long count for the main crystal. When the RC oscillator was also unpowered, a number of reference ticks for its start-up come first. The sequencer itself runs on an always-on clock. A per-peripheral enable register decides which peripherals are clocked while the processor runs or idles.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state code is 0 (run), `cpu_clk_en`, `main_osc_en`, `rc_osc_pwr` and `rc_out_en` are 1, `waking`, `pll_en`, `pll_connect` and `div_clr` are 0, and `periph_clk_en` equals the parameter `PEN_RESET`.
- R2: In run, a write with data 1, 2 or 3 enters idle, sleep or power-down at that clock edge, and `pwr_state` reports that code. A write with data 0 leaves the block in run.
- R3: In idle only the processor clock is off. Peripheral clocks follow their enable bits and both oscillators stay on. `irq_wake` or `async_wake` returns the block to run at the next edge, with no settle count.
- R4: In sleep the main oscillator, all peripheral clocks and the RC output are off, but the RC supply stays on. `irq_wake` alone does not end sleep.
- R5: In power-down, `rc_osc_pwr` is also 0.
- R6: Entering sleep or power-down clears `pll_en` and `pll_connect` and raises `div_clr` for exactly the first cycle of that level. The PLL stays off after the wake until software writes it again.
- R7: On `async_wake` from sleep with the RC oscillator as source at entry (`clk_src_rc`=1), `cpu_clk_en` returns to 1 exactly `RC_SETTLE` edges after the edge that samples the wake. `waking` is 1 in between.
- R8: On `async_wake` from sleep or power-down with the main oscillator as source at entry, `cpu_clk_en` returns to 1 exactly `MAIN_SETTLE` edges after the edge that samples the wake.
- R9: On `async_wake` from power-down with the RC source, the block first counts `STARTUP_TICKS` pulses of `ref_tick`, keeping `cpu_clk_en` at 0. `cpu_clk_en` then returns to 1 exactly `RC_SETTLE` edges after the edge that samples the last counted tick.
- R10: Writes to the mode, peripheral enable and PLL registers are ignored in every state other than run, including the wake count and its last cycle.
- R11: In run, bit i of `periph_clk_en` equals bit i of the last value written through `pen_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Free-running reference tick for RC start-up timing |
| clk_src_rc | input | 1 | 1 when the RC oscillator is the system clock source |
| mode_wr | input | 1 | Mode request write strobe |
| mode_wr_data | input | 2 | Requested level: 1 idle, 2 sleep, 3 power-down |
| irq_wake | input | 1 | Any enabled interrupt (wakes idle) |
| async_wake | input | 1 | Clock-free interrupt (wakes any level) |
| pen_wr | input | 1 | Peripheral enable write strobe |
| pen_wr_data | input | NPERIPH | Peripheral enable value |
| pll_wr | input | 1 | PLL control write strobe |
| pll_wr_en | input | 1 | PLL enable value |
| pll_wr_conn | input | 1 | PLL connect value |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| periph_clk_en | output | NPERIPH | Per-peripheral clock gate enables |
| main_osc_en | output | 1 | Main oscillator enable |
| rc_osc_pwr | output | 1 | RC oscillator supply enable |
| rc_out_en | output | 1 | RC oscillator output enable |
| pll_en | output | 1 | PLL enable |
| pll_connect | output | 1 | PLL connected as clock source |
| div_clr | output | 1 | One-cycle clear for the processor and USB dividers |
| pwr_state | output | 2 | 0 run, 1 idle, 2 sleep, 3 power-down |
| waking | output | 1 | Wake-up count in progress |

## Verification
Two events can fall on the same edge: a mode request write and the end of the wake count. The bench holds `mode_wr` with a sleep code from the first settle cycle through the edge that ends the count, so the final settle edge sees both at once. It passes only if the block returns to run, reports state 0 and stays there on the following cycles. This shows that the request was dropped and not taken up once the processor clock was released.

// File: rtl/pms_pkg.sv
`timescale 1ns/1ps
package pms_pkg;
   typedef enum logic [2:0] {
      PS_RUN, PS_IDLE, PS_SLEEP, PS_PDOWN, PS_START, PS_SETTLE
   } pms_state_e;

   localparam logic [1:0] CODE_RUN   = 2'd0;
   localparam logic [1:0] CODE_IDLE  = 2'd1;
   localparam logic [1:0] CODE_SLEEP = 2'd2;
   localparam logic [1:0] CODE_PDOWN = 2'd3;
endpackage

// File: rtl/pms_fsm.sv
`timescale 1ns/1ps
module pms_fsm
   import pms_pkg::*;
#(
   parameter int RC_SETTLE     = 4,
   parameter int MAIN_SETTLE   = 4096,
   parameter int STARTUP_TICKS = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [1:0] mode_wr_data,
   input  logic       clk_src_rc,
   input  logic       irq_wake,
   input  logic       async_wake,
   input  logic       ref_tick,
   output pms_state_e st_q,
   output logic [1:0] status,
   output logic       enter_deep,
   output logic       div_clr
);
   localparam int MAXC  = (MAIN_SETTLE > RC_SETTLE) ? MAIN_SETTLE : RC_SETTLE;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam bit HAS_START = (STARTUP_TICKS > 0);
   localparam logic [CNT_W-1:0] RC_LOAD   = CNT_W'(RC_SETTLE - 1);
   localparam logic [CNT_W-1:0] MAIN_LOAD = CNT_W'(MAIN_SETTLE - 1);

   if (RC_SETTLE < 1) begin : g_bad_rc
      $error("RC_SETTLE must be at least 1");
   end
   if (MAIN_SETTLE < 1) begin : g_bad_main
      $error("MAIN_SETTLE must be at least 1");
   end
   if (STARTUP_TICKS < 0) begin : g_bad_tick
      $error("STARTUP_TICKS must not be negative");
   end

   pms_state_e       st_d;
   logic [1:0]       mode_q;
   logic             src_rc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start_done;
   logic             load_settle;
   logic             settle_done;

   // RC start-up tick counter, present only when a start-up wait exists
   if (HAS_START) begin : g_start
      localparam int TK_W = $clog2(STARTUP_TICKS + 1);
      logic [TK_W-1:0] tk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                tk_q <= TK_W'(STARTUP_TICKS);
         else if (st_q != PS_START) tk_q <= TK_W'(STARTUP_TICKS);
         else if (ref_tick)         tk_q <= tk_q - 1'b1;
      end
      assign start_done = (st_q == PS_START) && ref_tick && (tk_q == TK_W'(1));
   end else begin : g_nostart
      assign start_done = 1'b0;
   end

   assign settle_done = (st_q == PS_SETTLE) && (cnt_q == '0);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PS_RUN: begin
            if (mode_wr) begin
               unique case (mode_wr_data)
                  CODE_IDLE:  st_d = PS_IDLE;
                  CODE_SLEEP: st_d = PS_SLEEP;
                  CODE_PDOWN: st_d = PS_PDOWN;
                  default:    st_d = PS_RUN;
               endcase
            end
         end
         PS_IDLE:   if (irq_wake || async_wake) st_d = PS_RUN;
         PS_SLEEP:  if (async_wake) st_d = PS_SETTLE;
         PS_PDOWN: begin
            if (async_wake) st_d = (src_rc_q && HAS_START) ? PS_START : PS_SETTLE;
         end
         PS_START:  if (start_done) st_d = PS_SETTLE;
         PS_SETTLE: if (settle_done) st_d = PS_RUN;
         default:   st_d = PS_RUN;
      endcase
   end

   assign load_settle = (st_d == PS_SETTLE) && (st_q != PS_SETTLE);
   assign enter_deep  = (st_q == PS_RUN) && ((st_d == PS_SLEEP) || (st_d == PS_PDOWN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PS_RUN;
         mode_q   <= CODE_RUN;
         src_rc_q <= 1'b1;
         cnt_q    <= '0;
         div_clr  <= 1'b0;
      end else begin
         st_q    <= st_d;
         div_clr <= enter_deep;
         if (st_q == PS_RUN && st_d != PS_RUN) begin
            mode_q   <= mode_wr_data;
            src_rc_q <= clk_src_rc;
         end
         if (load_settle)            cnt_q <= src_rc_q ? RC_LOAD : MAIN_LOAD;
         else if (st_q == PS_SETTLE) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign status = (st_q == PS_RUN) ? CODE_RUN : mode_q;

   AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_IDLE) && (irq_wake || async_wake) |=> (st_q == PS_RUN)); // R3
   AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SLEEP) && !async_wake |=> (st_q == PS_SLEEP)); // R4
   AST_NO_REQ_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SETTLE) || (st_q == PS_START) |=>
      (st_q == PS_SETTLE) || (st_q == PS_START) || (st_q == PS_RUN)); // R10
   AST_SETTLE_END: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_SETTLE) && (cnt_q == '0) |=> (st_q == PS_RUN)); // R7
endmodule

// File: rtl/pms_gates.sv
`timescale 1ns/1ps
module pms_gates
   import pms_pkg::*;
#(
   parameter int                    NPERIPH   = 8,
   parameter logic [NPERIPH-1:0]    PEN_RESET = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pms_state_e         st_q,
   input  logic               enter_deep,
   input  logic               pen_wr,
   input  logic [NPERIPH-1:0] pen_wr_data,
   input  logic               pll_wr,
   input  logic               pll_wr_en,
   input  logic               pll_wr_conn,
   output logic               cpu_clk_en,
   output logic [NPERIPH-1:0] periph_clk_en,
   output logic               main_osc_en,
   output logic               rc_osc_pwr,
   output logic               rc_out_en,
   output logic               pll_en,
   output logic               pll_connect
);
   if (NPERIPH < 1) begin : g_bad_np
      $error("NPERIPH must be at least 1");
   end

   logic               in_run;
   logic               deep;
   logic               periph_live;
   logic [NPERIPH-1:0] pen_q;
   logic               pll_en_q;
   logic               pll_conn_q;

   assign in_run      = (st_q == PS_RUN);
   assign deep        = (st_q == PS_SLEEP) || (st_q == PS_PDOWN);
   assign periph_live = in_run || (st_q == PS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pen_q <= PEN_RESET;
      else if (pen_wr && in_run) pen_q <= pen_wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_en_q   <= 1'b0;
         pll_conn_q <= 1'b0;
      end else if (enter_deep) begin
         pll_en_q   <= 1'b0;
         pll_conn_q <= 1'b0;
      end else if (pll_wr && in_run) begin
         pll_en_q   <= pll_wr_en;
         pll_conn_q <= pll_wr_conn;
      end
   end

   for (genvar i = 0; i < NPERIPH; i++) begin : g_pgate
      assign periph_clk_en[i] = pen_q[i] & periph_live;
   end

   assign cpu_clk_en  = in_run;
   assign main_osc_en = !deep;
   assign rc_out_en   = !deep;
   assign rc_osc_pwr  = (st_q != PS_PDOWN);
   assign pll_en      = pll_en_q;
   assign pll_connect = pll_conn_q & pll_en_q;

   AST_PLL_OFF_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      deep |-> !pll_en_q && !pll_conn_q); // R6
   AST_PEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_run |=> $stable(pen_q)); // R10
endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int                 NPERIPH       = 8,
   parameter logic [NPERIPH-1:0] PEN_RESET     = '1,
   parameter int                 RC_SETTLE     = 4,
   parameter int                 MAIN_SETTLE   = 4096,
   parameter int                 STARTUP_TICKS = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_tick,
   input  logic               clk_src_rc,
   input  logic               mode_wr,
   input  logic [1:0]         mode_wr_data,
   input  logic               irq_wake,
   input  logic               async_wake,
   input  logic               pen_wr,
   input  logic [NPERIPH-1:0] pen_wr_data,
   input  logic               pll_wr,
   input  logic               pll_wr_en,
   input  logic               pll_wr_conn,
   output logic               cpu_clk_en,
   output logic [NPERIPH-1:0] periph_clk_en,
   output logic               main_osc_en,
   output logic               rc_osc_pwr,
   output logic               rc_out_en,
   output logic               pll_en,
   output logic               pll_connect,
   output logic               div_clr,
   output logic [1:0]         pwr_state,
   output logic               waking
);
   pms_state_e st_q;
   logic       enter_deep;

   pms_fsm #(
      .RC_SETTLE(RC_SETTLE), .MAIN_SETTLE(MAIN_SETTLE), .STARTUP_TICKS(STARTUP_TICKS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wr_data(mode_wr_data),
      .clk_src_rc(clk_src_rc), .irq_wake(irq_wake), .async_wake(async_wake),
      .ref_tick(ref_tick), .st_q(st_q), .status(pwr_state),
      .enter_deep(enter_deep), .div_clr(div_clr)
   );

   pms_gates #(.NPERIPH(NPERIPH), .PEN_RESET(PEN_RESET)) u_gates (
      .clk(clk), .rst_n(rst_n), .st_q(st_q), .enter_deep(enter_deep),
      .pen_wr(pen_wr), .pen_wr_data(pen_wr_data), .pll_wr(pll_wr),
      .pll_wr_en(pll_wr_en), .pll_wr_conn(pll_wr_conn),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .main_osc_en(main_osc_en), .rc_osc_pwr(rc_osc_pwr), .rc_out_en(rc_out_en),
      .pll_en(pll_en), .pll_connect(pll_connect)
   );

   assign waking = (st_q == PS_START) || (st_q == PS_SETTLE);

   AST_WAKE_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      waking |-> !cpu_clk_en); // R9
   AST_DIVCLR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      div_clr |=> !div_clr); // R6
   AST_DIVCLR_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      div_clr |-> !main_osc_en && !cpu_clk_en); // R6
   AST_PDOWN_RC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == CODE_PDOWN) && !waking |-> !rc_osc_pwr); // R5
endmodule

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
   localparam int NP   = 8;
   localparam int RCS  = 4;
   localparam int MNS  = 4096;
   localparam int TICKS = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_tick = 1'b0, clk_src_rc = 1'b1;
   logic          mode_wr = 1'b0;
   logic [1:0]    mode_wr_data = 2'd0;
   logic          irq_wake = 1'b0, async_wake = 1'b0;
   logic          pen_wr = 1'b0;
   logic [NP-1:0] pen_wr_data = '0;
   logic          pll_wr = 1'b0, pll_wr_en = 1'b0, pll_wr_conn = 1'b0;
   logic          cpu_clk_en, main_osc_en, rc_osc_pwr, rc_out_en;
   logic          pll_en, pll_connect, div_clr, waking;
   logic [NP-1:0] periph_clk_en;
   logic [1:0]    pwr_state;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   pwr_mode_seq #(.NPERIPH(NP), .PEN_RESET(8'hFF), .RC_SETTLE(RCS),
                  .MAIN_SETTLE(MNS), .STARTUP_TICKS(TICKS)) uut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .clk_src_rc(clk_src_rc),
      .mode_wr(mode_wr), .mode_wr_data(mode_wr_data), .irq_wake(irq_wake),
      .async_wake(async_wake), .pen_wr(pen_wr), .pen_wr_data(pen_wr_data),
      .pll_wr(pll_wr), .pll_wr_en(pll_wr_en), .pll_wr_conn(pll_wr_conn),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .main_osc_en(main_osc_en), .rc_osc_pwr(rc_osc_pwr), .rc_out_en(rc_out_en),
      .pll_en(pll_en), .pll_connect(pll_connect), .div_clr(div_clr),
      .pwr_state(pwr_state), .waking(waking)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic write_mode(input logic [1:0] m);
      @(negedge clk); mode_wr = 1'b1; mode_wr_data = m;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   // pulse async_wake, then count edges until cpu_clk_en returns
   task automatic wake_count(output int n);
      @(negedge clk); async_wake = 1'b1;
      @(negedge clk); async_wake = 1'b0;
      n = 0;
      while (!cpu_clk_en && n < 6000) begin
         @(negedge clk); n++;
      end
   endtask

   task automatic t_reset();
      check("R1", "state", pwr_state, 0);
      check("R1", "cpu_clk_en", cpu_clk_en, 1);
      check("R1", "periph", periph_clk_en, 8'hFF);
      check("R1", "oscs", {main_osc_en, rc_osc_pwr, rc_out_en}, 3'b111);
      check("R1", "pll/div/waking", {pll_en, pll_connect, div_clr, waking}, 0);
   endtask

   task automatic t_mode_zero();
      write_mode(2'd0);
      check("R2", "code 0 stays run", pwr_state, 0);
      check("R2", "cpu stays on", cpu_clk_en, 1);
   endtask

   task automatic t_periph_idle();
      @(negedge clk); pen_wr = 1'b1; pen_wr_data = 8'hA5;
      @(negedge clk); pen_wr = 1'b0;
      check("R11", "periph after write", periph_clk_en, 8'hA5);
      write_mode(2'd1);
      check("R2", "idle code", pwr_state, 1);
      check("R3", "idle cpu off", cpu_clk_en, 0);
      check("R3", "idle periph", periph_clk_en, 8'hA5);
      check("R3", "idle oscs on", {main_osc_en, rc_osc_pwr, rc_out_en}, 3'b111);
      @(negedge clk); pen_wr = 1'b1; pen_wr_data = 8'h0F;
      @(negedge clk); pen_wr = 1'b0;
      check("R10", "pen write in idle ignored", periph_clk_en, 8'hA5);
      irq_wake = 1'b1;
      @(negedge clk); irq_wake = 1'b0;
      check("R3", "irq ends idle", pwr_state, 0);
      check("R3", "cpu back", cpu_clk_en, 1);
      check("R11", "periph kept", periph_clk_en, 8'hA5);
   endtask

   task automatic t_sleep_rc();
      int n;
      @(negedge clk); pll_wr = 1'b1; pll_wr_en = 1'b1; pll_wr_conn = 1'b1;
      @(negedge clk); pll_wr = 1'b0;
      check("R6", "pll on before", {pll_en, pll_connect}, 2'b11);
      clk_src_rc = 1'b1;
      write_mode(2'd2);
      check("R2", "sleep code", pwr_state, 2);
      check("R6", "div_clr first cycle", div_clr, 1);
      check("R6", "pll off", {pll_en, pll_connect}, 0);
      check("R4", "sleep gates", {cpu_clk_en, main_osc_en, rc_out_en}, 0);
      check("R4", "rc powered", rc_osc_pwr, 1);
      check("R4", "periph dark", periph_clk_en, 0);
      @(negedge clk);
      check("R6", "div_clr one cycle", div_clr, 0);
      irq_wake = 1'b1;
      @(negedge clk); irq_wake = 1'b0;
      @(negedge clk);
      check("R4", "irq ignored in sleep", pwr_state, 2);
      clk_src_rc = 1'b0; // change after entry must not matter
      wake_count(n);
      check("R7", "rc sleep wake edges", n, RCS);
      check("R7", "back to run", pwr_state, 0);
      check("R6", "pll stays off", {pll_en, pll_connect}, 0);
      clk_src_rc = 1'b1;
   endtask

   task automatic t_sleep_main();
      int n;
      clk_src_rc = 1'b0;
      write_mode(2'd2);
      wake_count(n);
      check("R8", "main sleep wake edges", n, MNS);
   endtask

   task automatic t_pdown_main();
      int n;
      clk_src_rc = 1'b0;
      write_mode(2'd3);
      check("R5", "pdown code", pwr_state, 3);
      check("R5", "rc unpowered", rc_osc_pwr, 0);
      wake_count(n);
      check("R8", "main pdown wake edges", n, MNS);
   endtask

   task automatic t_pdown_rc();
      int n, early;
      clk_src_rc = 1'b1;
      write_mode(2'd3);
      check("R5", "rc unpowered", rc_osc_pwr, 0);
      check("R6", "div_clr in pdown", div_clr, 1);
      @(negedge clk); async_wake = 1'b1;
      @(negedge clk); async_wake = 1'b0;
      check("R9", "waking in startup", waking, 1);
      early = 0;
      for (int k = 0; k < TICKS; k++) begin
         repeat (3) begin
            @(negedge clk);
            if (cpu_clk_en) early++;
         end
         ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
         if (cpu_clk_en) early++;
      end
      check("R9", "cpu held during startup", early, 0);
      n = 0;
      while (!cpu_clk_en && n < 100) begin
         @(negedge clk); n++;
      end
      check("R9", "edges after last tick", n, RCS);
   endtask

   task automatic t_req_in_wake();
      clk_src_rc = 1'b1;
      write_mode(2'd2);
      @(negedge clk); async_wake = 1'b1;
      @(negedge clk); async_wake = 1'b0;
      mode_wr = 1'b1; mode_wr_data = 2'd2;   // held over every settle edge
      @(negedge clk); pen_wr = 1'b1; pen_wr_data = 8'h00;
      repeat (RCS - 1) @(negedge clk);
      mode_wr = 1'b0; pen_wr = 1'b0;
      check("R10", "request at count end dropped", pwr_state, 0);
      check("R10", "cpu released", cpu_clk_en, 1);
      @(negedge clk);
      check("R10", "still run", pwr_state, 0);
      check("R10", "pen write in wake ignored", periph_clk_en, 8'hA5);
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_zero();
      t_periph_idle();
      t_sleep_rc();
      t_sleep_main();
      t_pdown_main();
      t_pdown_rc();
      t_req_in_wake();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule